// File: doc/BRIEF.md
# Keyboard controller host mailbox

This block is a byte-wide, two-way mailbox that sits between a host bus and an embedded controller CPU, in the manner of a PC keyboard controller. The host writes bytes into an input data register, and the controller picks them up. The controller writes bytes into an output data register, and the host picks them up. Every host write is tagged as a command or as data, according to the host address bit `host_a2_i`.

A status register shows both sides how full the mailbox is. Its output-full and input-full flags clear themselves when the far side reads the matching data register. The remaining status bits are free flags that the controller writes. An interrupt tells the controller that input is waiting, gated by an enable input. When the host and the controller act in the same cycle, a fixed priority settles each flag, so that no byte is lost.

Top module: `kb_mailbox`

## Requirements
- R1: After reset the status register reads 00h, both data registers read 00h and `ctl_irq_o` is low.
- R2: A host write (`host_cs_i` and `host_wr_i`) at either address loads the input data register and sets status bit 1 (input full). Status bit 3 takes the value of `host_a2_i` (1 = command, 0 = data).
- R3: A controller read of the data address (`ctl_addr_i`=0) returns the input data register and clears input full.
- R4: `ctl_irq_o` is high exactly when input full is set and `ctl_irq_en_i` is high.
- R5: A controller write to the data address loads the output data register and sets status bit 0 (output full).
- R6: A host read with `host_a2_i`=0 returns the output data register and clears output full.
- R7: A host read with `host_a2_i`=1 returns the status register and leaves every flag and register unchanged.
- R8: A controller write to the status address (`ctl_addr_i`=1) loads status bits 2 and 7..4 from the write data. Bits 0, 1 and 3 are left untouched (write mask F4h).
- R9: When a host write and a controller data read fall in the same cycle, the read returns the old input byte, and input full stays set with the new byte.
- R10: When a controller data write and a host data read fall in the same cycle, the host receives the old output byte, and output full stays set.
- R11: A host write while input full is already set overwrites the input byte.
- R12: Read data outputs are 00h in any cycle without a read strobe on that side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_cs_i | input | 1 | Host select |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_a2_i | input | 1 | Host address bit: 1 status/command, 0 data |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Host read data |
| ctl_wr_i | input | 1 | Controller write strobe |
| ctl_rd_i | input | 1 | Controller read strobe |
| ctl_addr_i | input | 1 | Controller address: 0 data, 1 status |
| ctl_wdata_i | input | DATA_W | Controller write data |
| ctl_rdata_o | output | DATA_W | Controller read data |
| ctl_irq_en_i | input | 1 | Input interrupt enable |
| ctl_irq_o | output | 1 | Input-waiting interrupt |

## Verification
The bench builds the block with its default DATA_W of 8, which is the width the status layout and the F4h free-flag mask assume. At that width, random byte values cover every pattern of the free flags and the data registers. The random traffic often places host and controller strobes in the same cycle, which brings both priority collisions and overwrites of a full input register within reach.

// File: rtl/kbm_pkg.sv
`timescale 1ns/1ps
package kbm_pkg;
  localparam int OBF_BIT = 0;
  localparam int IBF_BIT = 1;
  localparam int CD_BIT  = 3;

  typedef struct packed {
    logic wr;
    logic rd_data;
  } host_req_t;

  typedef struct packed {
    logic wr_data;
    logic wr_stat;
    logic rd_data;
  } ctl_req_t;
endpackage

// File: rtl/kbm_host_port.sv
`timescale 1ns/1ps
module kbm_host_port
  import kbm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              a2_i,
  input  logic [DATA_W-1:0] out_data_i,
  input  logic [DATA_W-1:0] status_i,
  output host_req_t         req_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    req_o.wr      = cs_i & wr_i;
    req_o.rd_data = cs_i & rd_i & ~a2_i;
  end

  always_comb begin
    rdata_o = '0;
    if (cs_i && rd_i) rdata_o = a2_i ? status_i : out_data_i;
  end
endmodule

// File: rtl/kbm_ctl_port.sv
`timescale 1ns/1ps
module kbm_ctl_port
  import kbm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [DATA_W-1:0] status_i,
  output ctl_req_t          req_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    req_o.wr_data = wr_i & ~addr_i;
    req_o.wr_stat = wr_i & addr_i;
    req_o.rd_data = rd_i & ~addr_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) rdata_o = addr_i ? status_i : in_data_i;
  end
endmodule

// File: rtl/kbm_regs.sv
`timescale 1ns/1ps
module kbm_regs
  import kbm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  host_req_t         host_req_i,
  input  logic              host_a2_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  ctl_req_t          ctl_req_i,
  input  logic [DATA_W-1:0] ctl_wdata_i,
  input  logic              irq_en_i,
  output logic [DATA_W-1:0] in_data_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] FLAG_MASK =
      (DATA_W'(1) << OBF_BIT) | (DATA_W'(1) << IBF_BIT) | (DATA_W'(1) << CD_BIT);
  localparam logic [DATA_W-1:0] GEN_MASK = ~FLAG_MASK;

  logic [DATA_W-1:0] in_q, out_q, gen_q;
  logic              ibf_q, obf_q, cd_q;
  logic              ibf_d, obf_d;

  // set beats clear: the new byte is the pending one
  always_comb begin
    ibf_d = ibf_q;
    if (host_req_i.wr)         ibf_d = 1'b1;
    else if (ctl_req_i.rd_data) ibf_d = 1'b0;
    obf_d = obf_q;
    if (ctl_req_i.wr_data)      obf_d = 1'b1;
    else if (host_req_i.rd_data) obf_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
      gen_q <= '0;
      ibf_q <= 1'b0;
      obf_q <= 1'b0;
      cd_q  <= 1'b0;
    end else begin
      ibf_q <= ibf_d;
      obf_q <= obf_d;
      if (host_req_i.wr) begin
        in_q <= host_wdata_i;
        cd_q <= host_a2_i;
      end
      if (ctl_req_i.wr_data) out_q <= ctl_wdata_i;
      if (ctl_req_i.wr_stat) gen_q <= ctl_wdata_i & GEN_MASK;
    end
  end

  always_comb begin
    status_o          = gen_q & GEN_MASK;
    status_o[OBF_BIT] = obf_q;
    status_o[IBF_BIT] = ibf_q;
    status_o[CD_BIT]  = cd_q;
  end

  assign in_data_o  = in_q;
  assign out_data_o = out_q;
  assign irq_o      = ibf_q & irq_en_i;

  AST_IBF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i.wr |=> status_o[IBF_BIT]);  // R2
  AST_CD_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i.wr |=> (status_o[CD_BIT] == $past(host_a2_i)));  // R2
  AST_IBF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_req_i.rd_data && !host_req_i.wr) |=> !status_o[IBF_BIT]);  // R3
  AST_OBF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_req_i.wr_data |=> (status_o[OBF_BIT] && out_data_o == $past(ctl_wdata_i)));  // R5
  AST_OBF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i.rd_data && !ctl_req_i.wr_data) |=> !status_o[OBF_BIT]);  // R6
  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_req_i.wr && !host_req_i.rd_data && !ctl_req_i.wr_data && !ctl_req_i.wr_stat
     && !ctl_req_i.rd_data) |=> $stable(status_o));  // R7
  AST_GEN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_req_i.wr_stat |=> ((status_o & GEN_MASK) == ($past(ctl_wdata_i) & GEN_MASK)));  // R8
endmodule

// File: rtl/kb_mailbox.sv
`timescale 1ns/1ps
module kb_mailbox
  import kbm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_cs_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic              host_a2_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              ctl_wr_i,
  input  logic              ctl_rd_i,
  input  logic              ctl_addr_i,
  input  logic [DATA_W-1:0] ctl_wdata_i,
  output logic [DATA_W-1:0] ctl_rdata_o,
  input  logic              ctl_irq_en_i,
  output logic              ctl_irq_o
);
  host_req_t         host_req;
  ctl_req_t          ctl_req;
  logic [DATA_W-1:0] in_data, out_data, status;

  kbm_host_port #(.DATA_W(DATA_W)) u_host (
    .cs_i(host_cs_i), .wr_i(host_wr_i), .rd_i(host_rd_i), .a2_i(host_a2_i),
    .out_data_i(out_data), .status_i(status), .req_o(host_req), .rdata_o(host_rdata_o)
  );

  kbm_ctl_port #(.DATA_W(DATA_W)) u_ctl (
    .wr_i(ctl_wr_i), .rd_i(ctl_rd_i), .addr_i(ctl_addr_i),
    .in_data_i(in_data), .status_i(status), .req_o(ctl_req), .rdata_o(ctl_rdata_o)
  );

  kbm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .host_req_i(host_req), .host_a2_i(host_a2_i),
    .host_wdata_i(host_wdata_i), .ctl_req_i(ctl_req), .ctl_wdata_i(ctl_wdata_i),
    .irq_en_i(ctl_irq_en_i), .in_data_o(in_data), .out_data_o(out_data),
    .status_o(status), .irq_o(ctl_irq_o)
  );

  AST_IRQ_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_cs_i && host_wr_i) |=> (ctl_irq_o == ctl_irq_en_i));  // R4
  AST_IDLE_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_rd_i && !ctl_rd_i) |-> (host_rdata_o == '0 && ctl_rdata_o == '0));  // R12
endmodule

// File: tb/kb_mailbox_tb_top.sv
`timescale 1ns/1ps
module kb_mailbox_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       h_cs = 0, h_wr = 0, h_rd = 0, h_a2 = 0;
  logic [7:0] h_wd = 0, h_rdat;
  logic       c_wr = 0, c_rd = 0, c_addr = 0, irq_en = 0;
  logic [7:0] c_wd = 0, c_rdat;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_in = 0, m_out = 0, m_gen = 0;
  logic       m_ibf = 0, m_obf = 0, m_cd = 0;

  always #5 clk = ~clk;

  kb_mailbox #(.DATA_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .host_cs_i(h_cs), .host_wr_i(h_wr), .host_rd_i(h_rd),
    .host_a2_i(h_a2), .host_wdata_i(h_wd), .host_rdata_o(h_rdat), .ctl_wr_i(c_wr),
    .ctl_rd_i(c_rd), .ctl_addr_i(c_addr), .ctl_wdata_i(c_wd), .ctl_rdata_o(c_rdat),
    .ctl_irq_en_i(irq_en), .ctl_irq_o(irq)
  );

  function automatic logic [7:0] exp_status();
    return {m_gen[7:4], m_cd, m_gen[2], m_ibf, m_obf};
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one bus cycle; checks read data before the edge, then advances the model
  task automatic cyc(input logic hw, input logic hr, input logic a2, input logic [7:0] hd,
                     input logic cw, input logic cr, input logic ca, input logic [7:0] cd,
                     input string tag);
    @(negedge clk);
    h_cs = hw | hr; h_wr = hw; h_rd = hr; h_a2 = a2; h_wd = hd;
    c_wr = cw; c_rd = cr; c_addr = ca; c_wd = cd;
    #1;
    if (hr) check(h_rdat, a2 ? exp_status() : m_out, tag != "" ? tag : (a2 ? "R7" : "R6"));
    else    check(h_rdat, 8'h00, "R12");
    if (cr) check(c_rdat, ca ? exp_status() : m_in, tag != "" ? tag : "R3");
    else    check(c_rdat, 8'h00, "R12");
    check({7'd0, irq}, {7'd0, m_ibf & irq_en}, "R4");
    @(posedge clk);
    if (hw) begin m_in = hd; m_cd = a2; m_ibf = 1; end
    else if (cr && !ca) m_ibf = 0;
    if (cw && !ca) begin m_out = cd; m_obf = 1; end
    else if (hr && !a2) m_obf = 0;
    if (cw && ca) m_gen = cd & 8'hF4;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 8'h00, 0, 0, 0, 8'h00, "");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset values
    cyc(0, 1, 1, 8'h00, 0, 0, 0, 8'h00, "R1");
    cyc(0, 1, 0, 8'h00, 0, 1, 0, 8'h00, "R1");
    check({7'd0, irq}, 8'h00, "R1");
    // R2 command write sets IBF and CD, R4 irq with enable
    irq_en = 1;
    cyc(1, 0, 1, 8'hD1, 0, 0, 0, 8'h00, "");
    cyc(0, 1, 1, 8'h00, 0, 0, 0, 8'h00, "R2");
    check(h_rdat, 8'h0A, "R2");
    // R7 status read changes nothing
    cyc(0, 1, 1, 8'h00, 0, 0, 0, 8'h00, "R7");
    check(h_rdat, 8'h0A, "R7");
    // R11 overwrite with data tag
    cyc(1, 0, 0, 8'h5A, 0, 0, 0, 8'h00, "");
    cyc(0, 0, 0, 8'h00, 0, 1, 0, 8'h00, "R11");
    check(c_rdat, 8'h5A, "R11");
    idle();
    check({7'd0, irq}, 8'h00, "R3");
    // R5, R6
    cyc(0, 0, 0, 8'h00, 1, 0, 0, 8'hA5, "");
    cyc(0, 1, 1, 8'h00, 0, 0, 0, 8'h00, "R5");
    check(h_rdat, 8'h01, "R5");
    cyc(0, 1, 0, 8'h00, 0, 0, 0, 8'h00, "R6");
    check(h_rdat, 8'hA5, "R6");
    cyc(0, 1, 1, 8'h00, 0, 0, 0, 8'h00, "R6");
    check(h_rdat, 8'h00, "R6");
    // R8 free flags, protected bits untouched
    cyc(0, 0, 0, 8'h00, 1, 0, 1, 8'hFF, "");
    cyc(0, 1, 1, 8'h00, 0, 0, 0, 8'h00, "R8");
    check(h_rdat, 8'hF4, "R8");
    // R9 collision on input side
    cyc(1, 0, 0, 8'h11, 0, 0, 0, 8'h00, "");
    cyc(1, 0, 1, 8'h22, 0, 1, 0, 8'h00, "R9");
    check(c_rdat, 8'h11, "R9");
    cyc(0, 0, 0, 8'h00, 0, 1, 0, 8'h00, "R9");
    check(c_rdat, 8'h22, "R9");
    // R10 collision on output side
    cyc(0, 0, 0, 8'h00, 1, 0, 0, 8'h33, "");
    cyc(0, 1, 0, 8'h00, 1, 0, 0, 8'h44, "R10");
    check(h_rdat, 8'h33, "R10");
    cyc(0, 1, 1, 8'h00, 0, 0, 0, 8'h00, "R10");
    check(h_rdat[0], 1'b1, "R10");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom;
      if (r[31:28] == 0) irq_en = ~irq_en;
      cyc(r[0] & r[1], r[2] & r[3], r[4], r[15:8],
          r[5] & r[6], r[7] & r[16], r[17], r[27:20], "");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule